// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a small synchronous static RAM whose shared data bus can alternate between reads and writes every clock without idle cycles. Each operation is presented with its address on one clock edge. The data for that operation moves on the bus two enabled clocks later. Write data is delayed through the same pipeline as read data, so a read and a write in consecutive cycles never compete for the bus.

An operation is started by a load cycle. A load cycle carries a new address and selects read or write. It can be followed by advance cycles, which step through the other words of the same aligned group of four. The order of those steps is either linear or interleaved, chosen by a strap input. Writes can be masked per byte lane.

A high clock enable freezes the whole device for that edge. Deselect cycles put idle slots into the pipeline. The bidirectional data bus is modelled as an input bus, an output bus and a drive-enable output.

Top module: `zt_sram`

## Requirements
- R1: The device is selected on a load cycle only when `chipEn1N`=0, `chipEn2`=1 and `chipEn3N`=0. Any other load cycle is an idle slot: no array word changes and `dataDrive` stays low in its data phase.
- R2: An edge at which `clkEnN` is high is ignored. No array write happens at that edge. `dataOut`, `dataDrive` and all pipeline and burst state hold their values.
- R3: With `advLoad`=0, a selected edge loads `addr` and the operation (`wrEnN`=0 means write, 1 means read). With `advLoad`=1, the next word of the burst is addressed, and the operation from the load is reused whatever `wrEnN` is.
- R4: Within a burst, the upper address bits [7:2] stay fixed. The low two bits of the k-th word after the start offset s are (s+k) mod 4 when `burstMode`=0, and s XOR k when `burstMode`=1. The count wraps after four words.
- R5: An advance cycle that follows a deselect stays idle: no write occurs and no read data is driven.
- R6: For an address sampled at enabled edge N, write data is taken from `dataIn` at enabled edge N+2, and read data appears on `dataOut` right after enabled edge N+2.
- R7: Lane 0 is bits [8:0] and lane 1 is bits [17:9]. A lane is written only if its bit in `byteWrN` is 0 at the address edge. A masked lane keeps its old contents.
- R8: `dataDrive` is high only during a read data phase while `outEnN` is low. It is low during write, idle and deselect data phases.
- R9: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued right after a write to the same address returns the new data.
- R10: After reset, the pipeline holds only idle slots and `dataDrive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clkEnN | input | 1 | Active-low clock enable; high ignores the edge |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| wrEnN | input | 1 | 0 = write, 1 = read, sampled on load cycles |
| byteWrN | input | 2 | Active-low byte-lane write strobes |
| advLoad | input | 1 | 0 = load new address, 1 = advance burst |
| burstMode | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| outEnN | input | 1 | Active-low output enable |
| addr | input | 8 | Word address |
| dataIn | input | 18 | Data bus, inbound half |
| dataOut | output | 18 | Data bus, outbound half |
| dataDrive | output | 1 | High when the block drives the data bus |

## Verification
The hardest situations to reach are those in which data-phase timing interacts with control that arrived earlier. Examples are a stall in the middle of a burst, a read that lands just after a write to the same word, and a continue cycle issued after a deselect. The stimulus drives every cycle explicitly. It pairs each address cycle with the `dataIn` value for the operation two enabled edges earlier and inserts stall edges between those two edges. Burst checks first fill an aligned group through a linear write burst that starts mid-group. They then read the group back in interleaved and linear orders from other start offsets, so every wrap of the counter is seen at the ports.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  parameter int ADDR_W      = 8;
  parameter int DATA_W      = 18;
  parameter int LANES       = 2;
  parameter int BURST_W     = 2;
  parameter int PIPE_STAGES = 2;

  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_t;

  // One pipeline slot: operation, word address and active-high lane enables.
  typedef struct packed {
    op_t               op;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lane;
  } cmd_t;

  // Strobes from control to datapath for the data phase now being served.
  typedef struct packed {
    logic              step;
    logic              wrStb;
    logic              rdStb;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lane;
  } strobe_t;

  function automatic logic [BURST_W-1:0] burstOffset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] count,
    input logic               interleave
  );
    return interleave ? (start ^ count) : (start + count);
  endfunction
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEnN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              wrEnN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              advLoad,
  input  logic              burstMode,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  localparam int LAST = PIPE_STAGES - 1;

  logic                     selected;
  logic                     active;
  logic [ADDR_W-1:BURST_W]  baseHi;
  logic [BURST_W-1:0]       startOff;
  logic [BURST_W-1:0]       burstCnt;
  logic [BURST_W-1:0]       nextCnt;
  op_t                      burstOp;
  cmd_t                     nextCmd;
  cmd_t                     pipe [PIPE_STAGES];

  assign selected = !chipEn1N && chipEn2 && !chipEn3N;
  assign nextCnt  = burstCnt + 1'b1;

  // Slot entering the pipeline at this edge.
  always_comb begin
    nextCmd = cmd_t'('0);
    if (!advLoad) begin
      if (selected) begin
        nextCmd.op   = wrEnN ? OP_RD : OP_WR;
        nextCmd.addr = addr;
        nextCmd.lane = wrEnN ? '0 : ~byteWrN;
      end
    end else if (active) begin
      nextCmd.op   = burstOp;
      nextCmd.addr = {baseHi, burstOffset(startOff, nextCnt, burstMode)};
      nextCmd.lane = (burstOp == OP_WR) ? ~byteWrN : '0;
    end
  end

  // Burst tracking: updated only on enabled edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      baseHi   <= '0;
      startOff <= '0;
      burstCnt <= '0;
      burstOp  <= OP_NOP;
    end else if (!clkEnN) begin
      if (!advLoad) begin
        active <= selected;
        if (selected) begin
          baseHi   <= addr[ADDR_W-1:BURST_W];
          startOff <= addr[BURST_W-1:0];
          burstCnt <= '0;
          burstOp  <= wrEnN ? OP_RD : OP_WR;
        end
      end else if (active) begin
        burstCnt <= nextCnt;
      end
    end
  end

  // Control pipeline, one slot per stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pipe[0] <= cmd_t'('0);
    else if (!clkEnN) pipe[0] <= nextCmd;
  end

  for (genvar g = 1; g < PIPE_STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pipe[g] <= cmd_t'('0);
      else if (!clkEnN) pipe[g] <= pipe[g-1];
    end
  end

  always_comb begin
    stb.step  = !clkEnN;
    stb.wrStb = !clkEnN && (pipe[LAST].op == OP_WR);
    stb.rdStb = !clkEnN && (pipe[LAST].op == OP_RD);
    stb.addr  = pipe[LAST].addr;
    stb.lane  = pipe[LAST].lane;
  end

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && !advLoad && !selected) |=> (pipe[0].op == OP_NOP)); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clkEnN |=> ($stable(pipe[LAST]) && $stable(active) && $stable(burstCnt))); // R2
  AST_OP_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && advLoad && active) |=> (pipe[0].op == $past(pipe[0].op))); // R3
  AST_BURST_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && advLoad && active) |=>
      (pipe[0].addr[ADDR_W-1:BURST_W] == $past(pipe[0].addr[ADDR_W-1:BURST_W]))); // R4
  AST_CONTINUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && advLoad && !active) |=> (pipe[0].op == OP_NOP)); // R5
endmodule

// File: rtl/zt_sram_dp.sv
module zt_sram_dp
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              rdValid;

  // Array write, lane by lane.
  always_ff @(posedge clk) begin
    if (stb.wrStb) begin
      for (int l = 0; l < LANES; l++) begin
        if (stb.lane[l]) mem[stb.addr][l*LANE_W +: LANE_W] <= dataIn[l*LANE_W +: LANE_W];
      end
    end
  end

  // Read data register and phase flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      dataOut <= '0;
    end else if (stb.step) begin
      rdValid <= stb.rdStb;
      if (stb.rdStb) dataOut <= mem[stb.addr];
    end
  end

  assign dataDrive = rdValid && !outEnN;

  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.step |=> ($stable(dataOut) && $stable(rdValid))); // R2
  AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rdStb |=> rdValid); // R6
  AST_NO_DRIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrStb |=> !dataDrive); // R8
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEnN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              wrEnN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              advLoad,
  input  logic              burstMode,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);
  strobe_t stb;

  zt_sram_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clkEnN    (clkEnN),
    .chipEn1N  (chipEn1N),
    .chipEn2   (chipEn2),
    .chipEn3N  (chipEn3N),
    .wrEnN     (wrEnN),
    .byteWrN   (byteWrN),
    .advLoad   (advLoad),
    .burstMode (burstMode),
    .addr      (addr),
    .stb       (stb)
  );

  zt_sram_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .dataIn    (dataIn),
    .outEnN    (outEnN),
    .dataOut   (dataOut),
    .dataDrive (dataDrive)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !dataDrive); // R10
endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clkEnN = 1'b0;
  logic        chipEn1N = 1'b1;
  logic        chipEn2 = 1'b0;
  logic        chipEn3N = 1'b1;
  logic        wrEnN = 1'b1;
  logic [1:0]  byteWrN = 2'b11;
  logic        advLoad = 1'b0;
  logic        burstMode = 1'b0;
  logic        outEnN = 1'b0;
  logic [7:0]  addr = '0;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut;
  logic        dataDrive;

  int checks = 0;
  int fails = 0;
  logic [17:0] got;

  always #5 clk = ~clk;

  zt_sram u_dut (
    .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN), .chipEn1N(chipEn1N), .chipEn2(chipEn2),
    .chipEn3N(chipEn3N), .wrEnN(wrEnN), .byteWrN(byteWrN), .advLoad(advLoad),
    .burstMode(burstMode), .outEnN(outEnN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: inputs set after the falling edge, outputs readable at the next falling edge.
  task automatic cyc(input logic cen, input logic sel, input logic we, input logic adv,
                     input logic [1:0] bw, input logic [7:0] a, input logic [17:0] d);
    clkEnN = cen; chipEn1N = !sel; chipEn2 = sel; chipEn3N = !sel;
    wrEnN = !we; advLoad = adv; byteWrN = bw; addr = a; dataIn = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] bw, input logic [17:0] d);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, bw, a, d);
  endtask
  task automatic rd(input logic [7:0] a, input logic [17:0] d);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, a, d);
  endtask
  task automatic nop(input logic [17:0] d);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 8'h00, d);
  endtask
  task automatic adv(input logic [1:0] bw, input logic [17:0] d);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, bw, 8'hFF, d);
  endtask
  task automatic stall(input logic [17:0] d);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'h00, d);
  endtask

  task automatic writeWord(input logic [7:0] a, input logic [1:0] bw, input logic [17:0] d);
    wr(a, bw, '0); nop('0); nop(d);
  endtask
  task automatic readWord(input logic [7:0] a, output logic [17:0] q);
    rd(a, '0); nop('0); nop('0);
    chk("R8 drive on read phase", {17'b0, dataDrive}, 18'd1);
    q = dataOut;
  endtask

  task automatic testReset;
    chk("R10 drive low after reset", {17'b0, dataDrive}, 18'd0);
    nop('0); nop('0); nop('0);
    chk("R10 idle pipeline", {17'b0, dataDrive}, 18'd0);
  endtask

  task automatic testAlternate;
    wr(8'h05, 2'b00, '0);
    wr(8'h06, 2'b00, '0);
    rd(8'h05, 18'h11111);
    chk("R8 no drive in write phase", {17'b0, dataDrive}, 18'd0);
    rd(8'h06, 18'h22222);
    chk("R8 no drive in write phase", {17'b0, dataDrive}, 18'd0);
    nop('0);
    chk("R6 read latency word A", dataOut, 18'h11111);
    chk("R9 drive during alternation", {17'b0, dataDrive}, 18'd1);
    nop('0);
    chk("R6 read latency word B", dataOut, 18'h22222);
    nop('0);
    chk("R8 no drive in idle phase", {17'b0, dataDrive}, 18'd0);
    // read right behind a write to the same word
    wr(8'h07, 2'b00, '0);
    rd(8'h07, '0);
    nop(18'h33333);
    nop('0);
    chk("R9 read after write same address", dataOut, 18'h33333);
    // write right behind a read
    rd(8'h05, '0);
    wr(8'h08, 2'b00, '0);
    nop('0);
    chk("R9 read before write", dataOut, 18'h11111);
    nop(18'h04444);
    readWord(8'h08, got);
    chk("R9 write after read", got, 18'h04444);
  endtask

  task automatic testStall;
    wr(8'h20, 2'b00, '0);
    stall(18'h3DEAD);
    nop('0);
    nop(18'h15555);
    readWord(8'h20, got);
    chk("R2 stalled edge does not capture data", got, 18'h15555);
    rd(8'h20, '0);
    nop('0);
    stall('0);
    chk("R2 stall delays read output", {17'b0, dataDrive}, 18'd0);
    nop('0);
    chk("R6 read counted in enabled edges", dataOut, 18'h15555);
    stall('0);
    chk("R2 output held in stall", dataOut, 18'h15555);
    chk("R2 drive held in stall", {17'b0, dataDrive}, 18'd1);
    nop('0);
  endtask

  task automatic testBytes;
    writeWord(8'h30, 2'b00, 18'h2A5A5);
    writeWord(8'h30, 2'b10, 18'h15A5A);
    readWord(8'h30, got);
    chk("R7 lane 0 only", got, {9'h152, 9'h05A});
    writeWord(8'h30, 2'b01, 18'h3FFFF);
    readWord(8'h30, got);
    chk("R7 lane 1 only", got, {9'h1FF, 9'h05A});
  endtask

  task automatic testBurst;
    burstMode = 1'b0;
    wr(8'h42, 2'b00, '0);
    adv(2'b00, '0);
    adv(2'b00, 18'd100);
    adv(2'b00, 18'd101);
    nop(18'd102);
    nop(18'd103);
    readWord(8'h42, got); chk("R4 linear write start", got, 18'd100);
    readWord(8'h43, got); chk("R4 linear write step", got, 18'd101);
    readWord(8'h40, got); chk("R4 linear write wrap", got, 18'd102);
    readWord(8'h41, got); chk("R3 burst write op carried", got, 18'd103);
    // interleaved read from offset 1: 1,0,3,2
    burstMode = 1'b1;
    rd(8'h41, '0); adv(2'b11, '0);
    adv(2'b11, '0); chk("R4 interleaved 1", dataOut, 18'd103);
    adv(2'b11, '0); chk("R4 interleaved 0", dataOut, 18'd102);
    nop('0);        chk("R4 interleaved 3", dataOut, 18'd101);
    nop('0);        chk("R4 interleaved 2", dataOut, 18'd100);
    // linear read from offset 3: 3,0,1,2
    burstMode = 1'b0;
    rd(8'h43, '0); adv(2'b11, '0);
    adv(2'b11, '0); chk("R4 linear read 3", dataOut, 18'd101);
    adv(2'b11, '0); chk("R4 linear read wrap 0", dataOut, 18'd102);
    nop('0);        chk("R4 linear read 1", dataOut, 18'd103);
    nop('0);        chk("R3 linear read 2", dataOut, 18'd100);
  endtask

  task automatic deselLoad(input logic e1n, input logic e2, input logic e3n, input logic [17:0] d);
    clkEnN = 1'b0; chipEn1N = e1n; chipEn2 = e2; chipEn3N = e3n;
    wrEnN = 1'b0; advLoad = 1'b0; byteWrN = 2'b00; addr = 8'h10; dataIn = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic testDeselect;
    writeWord(8'h10, 2'b00, 18'h0ABCD);
    deselLoad(1'b1, 1'b1, 1'b0, 18'h3FFFF);
    deselLoad(1'b0, 1'b0, 1'b0, 18'h3FFFF);
    chk("R1 no drive while deselected", {17'b0, dataDrive}, 18'd0);
    deselLoad(1'b0, 1'b1, 1'b1, 18'h3FFFF);
    adv(2'b00, 18'h3FFFF);
    chk("R5 no drive for continue", {17'b0, dataDrive}, 18'd0);
    adv(2'b00, 18'h3FFFF);
    nop(18'h3FFFF);
    nop(18'h3FFFF);
    readWord(8'h10, got);
    chk("R1 deselected writes ignored", got, 18'h0ABCD);
    writeWord(8'h11, 2'b00, 18'h01234);
    readWord(8'h11, got);
    chk("R5 continue after deselect wrote nothing", got, 18'h01234);
  endtask

  task automatic testOutEnable;
    writeWord(8'h50, 2'b00, 18'h2BEEF);
    rd(8'h50, '0);
    nop('0);
    outEnN = 1'b1;
    nop('0);
    chk("R8 drive off with output enable high", {17'b0, dataDrive}, 18'd0);
    outEnN = 1'b0;
    #1;
    chk("R8 drive on with output enable low", {17'b0, dataDrive}, 18'd1);
    chk("R6 data present", dataOut, 18'h2BEEF);
    nop('0);
    chk("R8 drive ends after phase", {17'b0, dataDrive}, 18'd0);
  endtask

  initial begin
    #200_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testAlternate();
    testStall();
    testBytes();
    testBurst();
    testDeselect();
    testOutEnable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule